// File: doc/BRIEF.md
# Segment Address Extension Unit

This block widens the 32-bit addresses a processor core produces into 36-bit physical addresses. It holds a table of sixteen independently programmable segments. Each segment names a logical window of power-of-two size, a physical base that replaces the upper address bits, and a set of access permissions. A write port loads one segment per cycle.

A lookup port takes an address and an access type. One cycle later it returns the translated physical address, or a fault flag with a zero address when the access cannot be served. When more than one segment matches, the segment with the highest index wins. Address bits below the segment size go through unchanged.

Top module: `seg_xlate`

## Requirements
- R1: After reset every segment is disabled, so every lookup faults. While no response is pending, `rsp_valid`, `rsp_fault` and `rsp_addr` are all zero.
- R2: When `cfg_we` is high at a clock edge, segment `cfg_idx` takes the values of `cfg_lbase`, `cfg_code`, `cfg_pbase` and `cfg_perm`. A lookup in the same cycle as a write still sees the old contents of that segment.
- R3: A size code c in the range 11 to 31 enables a segment of 2^(c+1) bytes, which gives 4 KB up to 4 GB. A code from 0 to 10 disables the segment.
- R4: An address matches an enabled segment when its bits at positions c+1 and above equal the same bits of the logical base (`cfg_lbase` supplies address bits 31:12). Base bits below the segment size are ignored, so a misaligned base is rounded down.
- R5: The physical address is the physical base (`cfg_pbase` supplies bits 35:12) with its bits below c+1 replaced by the same bits of the logical address. Bits 35:32 always come from the physical base.
- R6: When several enabled segments match, only the one with the highest index is used, even if a lower one would grant the access.
- R7: The access type encodes read as 0, write as 1 and execute as 2. These are checked against `cfg_perm` bit 0, bit 1 and bit 2 of the winning segment. Type 3 always faults. A permission bit of 0 causes a fault.
- R8: A lookup that matches no enabled segment, or that is denied by R7, returns `rsp_fault` high and `rsp_addr` zero.
- R9: Each lookup with `req_valid` high at a clock edge gives a response with `rsp_valid` high in the following cycle. A cycle without a request gives no response in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Segment write enable |
| cfg_idx | input | 4 | Segment index to write |
| cfg_lbase | input | 20 | Logical base, address bits 31:12 |
| cfg_code | input | 5 | Size code |
| cfg_pbase | input | 24 | Physical base, address bits 35:12 |
| cfg_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Logical address |
| req_type | input | 2 | Access type (0 read, 1 write, 2 execute, 3 reserved) |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_addr | output | 36 | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation or permission fault |

## Verification
The hardest case to reach from the ports is a nested overlap. In this case a high-index segment with a narrow permission sits inside a low-index segment that would allow the access, and it must deny it. The same goes for addresses exactly one byte below, at, and one byte past a segment edge.

Directed steps first build a whole-space segment at index 0 with nested windows above it. They then probe each edge and every access type. After that a long random phase rewrites segments with biased small sizes. It draws addresses relative to the current bases: base, last byte, one past, one before, or anywhere inside. Overlaps and edges therefore occur thousands of times. Every cycle is compared against a range-arithmetic model.

// File: rtl/segx_pkg.sv
package segx_pkg;
    localparam int LA_W     = 32;
    localparam int PA_W     = 36;
    localparam int PG_W     = 12;
    localparam int LB_W     = LA_W - PG_W;
    localparam int PB_W     = PA_W - PG_W;
    localparam int CODE_W   = 5;
    localparam int PERM_W   = 3;
    localparam int MIN_CODE = 11;
    localparam int TYPE_W   = 2;

    typedef enum logic [TYPE_W-1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_EX  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef struct packed {
        logic [LB_W-1:0]   lbase;
        logic [CODE_W-1:0] code;
        logic [PB_W-1:0]   pbase;
        logic [PERM_W-1:0] perm;
    } seg_t;

    typedef struct packed {
        logic            valid;
        logic            fault;
        logic [PA_W-1:0] addr;
    } rsp_t;
endpackage

// File: rtl/seg_table.sv
module seg_table
    import segx_pkg::*;
#(
    parameter int NUM_SEG = 16,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  seg_t             wdata,
    output seg_t             tbl [NUM_SEG]
);
    seg_t tbl_d [NUM_SEG];
    seg_t tbl_q [NUM_SEG];

    always_comb begin
        for (int i = 0; i < NUM_SEG; i++) begin
            tbl_d[i] = tbl_q[i];
            if (we && (idx == IDX_W'(i))) begin
                tbl_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rst) begin
                tbl_q[i] <= '0;
            end else begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    assign tbl = tbl_q;
endmodule

// File: rtl/seg_match.sv
module seg_match
    import segx_pkg::*;
#(
    parameter int NUM_SEG = 16
) (
    input  seg_t            tbl  [NUM_SEG],
    input  logic [LA_W-1:0] addr,
    output logic            hit  [NUM_SEG],
    output logic [PA_W-1:0] phys [NUM_SEG]
);
    localparam int EXT_W = PA_W - LA_W;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        logic [LA_W:0]   wide_mask;
        logic [LA_W-1:0] off_mask;
        logic [LA_W-1:0] lbase_full;
        logic [PA_W-1:0] pbase_full;
        logic            enabled;

        always_comb begin
            wide_mask  = ({{LA_W{1'b0}}, 1'b1} << (int'(tbl[g].code) + 1)) - 1'b1;
            off_mask   = wide_mask[LA_W-1:0];
            lbase_full = {tbl[g].lbase, {PG_W{1'b0}}};
            pbase_full = {tbl[g].pbase, {PG_W{1'b0}}};
            enabled    = (tbl[g].code >= CODE_W'(MIN_CODE));
            hit[g]     = enabled && (((addr ^ lbase_full) & ~off_mask) == '0);
            phys[g]    = (pbase_full & ~{{EXT_W{1'b0}}, off_mask})
                       | {{EXT_W{1'b0}}, addr & off_mask};
        end
    end
endmodule

// File: rtl/seg_pick.sv
module seg_pick
    import segx_pkg::*;
#(
    parameter int NUM_SEG = 16
) (
    input  seg_t              tbl  [NUM_SEG],
    input  logic              hit  [NUM_SEG],
    input  logic [PA_W-1:0]   phys [NUM_SEG],
    input  logic [TYPE_W-1:0] acc,
    output logic              ok,
    output logic [PA_W-1:0]   out_addr
);
    logic              any_hit;
    logic [PERM_W-1:0] win_perm;
    logic [PA_W-1:0]   win_phys;
    logic              allowed;

    always_comb begin
        any_hit  = 1'b0;
        win_perm = '0;
        win_phys = '0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (hit[i]) begin
                any_hit  = 1'b1;
                win_perm = tbl[i].perm;
                win_phys = phys[i];
            end
        end
        unique case (acc_e'(acc))
            ACC_RD:  allowed = win_perm[0];
            ACC_WR:  allowed = win_perm[1];
            ACC_EX:  allowed = win_perm[2];
            default: allowed = 1'b0;
        endcase
        ok       = any_hit && allowed;
        out_addr = ok ? win_phys : '0;
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import segx_pkg::*;
#(
    parameter int NUM_SEG = 16,
    localparam int IDX_W  = $clog2(NUM_SEG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [LB_W-1:0]   cfg_lbase,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic [PB_W-1:0]   cfg_pbase,
    input  logic [PERM_W-1:0] cfg_perm,
    input  logic              req_valid,
    input  logic [LA_W-1:0]   req_addr,
    input  logic [TYPE_W-1:0] req_type,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_addr,
    output logic              rsp_fault
);
    seg_t            wdata;
    seg_t            tbl  [NUM_SEG];
    logic            hit  [NUM_SEG];
    logic [PA_W-1:0] phys [NUM_SEG];
    logic            ok;
    logic [PA_W-1:0] out_addr;
    rsp_t            rsp_d;
    rsp_t            rsp_q;

    always_comb begin
        wdata.lbase = cfg_lbase;
        wdata.code  = cfg_code;
        wdata.pbase = cfg_pbase;
        wdata.perm  = cfg_perm;
    end

    seg_table #(.NUM_SEG(NUM_SEG)) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .idx   (cfg_idx),
        .wdata (wdata),
        .tbl   (tbl)
    );

    seg_match #(.NUM_SEG(NUM_SEG)) u_match (
        .tbl  (tbl),
        .addr (req_addr),
        .hit  (hit),
        .phys (phys)
    );

    seg_pick #(.NUM_SEG(NUM_SEG)) u_pick (
        .tbl      (tbl),
        .hit      (hit),
        .phys     (phys),
        .acc      (req_type),
        .ok       (ok),
        .out_addr (out_addr)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.fault = !ok;
            rsp_d.addr  = out_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_addr  = rsp_q.addr;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import segx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [LA_W-1:0]   req_addr,
    input logic [TYPE_W-1:0] req_type,
    input logic              rsp_valid,
    input logic [PA_W-1:0]   rsp_addr,
    input logic              rsp_fault
);
    // R8
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_addr == '0));

    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_addr == '0));

    // R7
    rsv_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_type == 2'd3) |=> rsp_fault);

    // R5
    low_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rst) |=> (rsp_fault || rsp_addr[PG_W-1:0] == $past(req_addr[PG_W-1:0])));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_type  (req_type),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .rsp_fault (rsp_fault)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG       = 16;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [19:0] cfg_lbase;
    logic [4:0]  cfg_code;
    logic [23:0] cfg_pbase;
    logic [2:0]  cfg_perm;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [1:0]  req_type;
    logic        rsp_valid;
    logic [35:0] rsp_addr;
    logic        rsp_fault;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_xlate u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_lbase(cfg_lbase), .cfg_code(cfg_code), .cfg_pbase(cfg_pbase),
        .cfg_perm(cfg_perm), .req_valid(req_valid), .req_addr(req_addr),
        .req_type(req_type), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_fault(rsp_fault)
    );

    int nvec = 0;
    int nerr = 0;
    int cycles = 0;

    // behavioural model state
    int unsigned m_lb   [NSEG];
    int          m_code [NSEG];
    longint      m_pb   [NSEG];
    int          m_perm [NSEG];

    bit          pend = 0;
    string       pend_tag;
    bit          e_v, e_f;
    longint      e_a;

    function automatic void model_clear();
        for (int i = 0; i < NSEG; i++) begin
            m_lb[i] = 0; m_code[i] = 0; m_pb[i] = 0; m_perm[i] = 0;
        end
    endfunction

    function automatic longint seg_size(int i);
        return longint'(1) << (m_code[i] + 1);
    endfunction

    function automatic longint seg_base(int i);
        longint b = longint'(m_lb[i]) << 12;
        return b - (b % seg_size(i));
    endfunction

    task automatic check_pending();
        if (pend) begin
            nvec++;
            if (rsp_valid !== e_v || rsp_fault !== e_f || rsp_addr !== e_a[35:0]) begin
                nerr++;
                $display("FAIL %s: got v=%0b f=%0b a=%h expected v=%0b f=%0b a=%h",
                         pend_tag, rsp_valid, rsp_fault, rsp_addr, e_v, e_f, e_a[35:0]);
            end
        end
        pend = 0;
    endtask

    task automatic step(string tag, bit we, int idx, int unsigned lb, int code,
                        int unsigned pb, int perm, bit rv, int unsigned addr, int typ);
        int found;
        @(negedge clk);
        check_pending();
        cfg_we = we; cfg_idx = idx[3:0]; cfg_lbase = lb[19:0]; cfg_code = code[4:0];
        cfg_pbase = pb[23:0]; cfg_perm = perm[2:0];
        req_valid = rv; req_addr = addr; req_type = typ[1:0];
        // expectation uses the table as it stands before this edge's write
        found = -1;
        for (int i = 0; i < NSEG; i++) begin
            if (m_code[i] >= 11) begin
                if (longint'(addr) >= seg_base(i) && longint'(addr) < seg_base(i) + seg_size(i))
                    found = i;
            end
        end
        e_v = rv; e_f = 0; e_a = 0;
        if (rv) begin
            if (found < 0 || typ == 3 || ((m_perm[found] >> typ) & 1) == 0) begin
                e_f = 1;
            end else begin
                longint pbf = m_pb[found] << 12;
                e_a = pbf - (pbf % seg_size(found)) + (longint'(addr) - seg_base(found));
            end
        end
        pend = 1; pend_tag = tag;
        if (we) begin
            m_lb[idx] = lb[19:0]; m_code[idx] = code & 31;
            m_pb[idx] = longint'(pb[23:0]); m_perm[idx] = perm & 7;
        end
    endtask

    task automatic wr(string tag, int idx, int unsigned lb, int code, int unsigned pb, int perm);
        step(tag, 1, idx, lb, code, pb, perm, 0, 0, 0);
    endtask

    task automatic rd(string tag, int unsigned addr, int typ);
        step(tag, 0, 0, 0, 0, 0, 0, 1, addr, typ);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                nerr++;
                $display("FAIL watchdog: got cycles=%0d expected below %0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
                $finish;
            end
        end
    end

    initial begin
        model_clear();
        rst = 1; cfg_we = 0; cfg_idx = 0; cfg_lbase = 0; cfg_code = 0; cfg_pbase = 0;
        cfg_perm = 0; req_valid = 0; req_addr = 0; req_type = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 outputs are zero in reset
        nvec++;
        if (rsp_valid !== 0 || rsp_fault !== 0 || rsp_addr !== 0) begin
            nerr++;
            $display("FAIL R1: got v=%0b f=%0b a=%h expected v=0 f=0 a=0", rsp_valid, rsp_fault, rsp_addr);
        end
        rst = 0;

        // R1 empty table faults everywhere
        rd("R1", 32'h0000_0000, 0);
        rd("R1", 32'hFFFF_FFFF, 1);
        rd("R1", 32'h8000_0000, 2);

        // R2 write with same-cycle lookup sees the old entry, next cycle the new one
        step("R2", 1, 3, 20'h80000, 15, 24'h123450, 7, 1, 32'h8000_0010, 0);
        rd("R2", 32'h8000_0010, 0);

        // R4 / R5 edges of a 64 KB window
        rd("R4", 32'h8000_0000, 1);
        rd("R4", 32'h8000_FFFF, 2);
        rd("R4", 32'h8001_0000, 0);
        rd("R4", 32'h7FFF_FFFF, 0);
        // misaligned base rounded down (16 KB)
        wr("R4", 5, 20'h40003, 13, 24'hA00007, 7);
        rd("R4", 32'h4000_0000, 0);
        rd("R5", 32'h4000_3FFF, 0);
        rd("R4", 32'h4000_4000, 0);

        // R3 code 10 disabled, code 31 covers everything
        wr("R3", 6, 20'h10000, 10, 24'h000100, 7);
        rd("R3", 32'h1000_0000, 0);
        wr("R3", 0, 20'h12345, 31, 24'h700000, 1);
        rd("R3", 32'h1234_5678, 0);
        rd("R5", 32'hFFFF_FFFF, 0);

        // R6 nested windows, highest index wins
        wr("R6", 9, 20'h80008, 12, 24'h000AB0, 7);
        rd("R6", 32'h8000_8100, 1);
        rd("R6", 32'h8000_7FFF, 1);
        rd("R6", 32'h8000_A000, 1);
        wr("R6", 2, 20'h80008, 14, 24'h333330, 7);
        rd("R6", 32'h8000_8004, 0);

        // R7 / R8 permissions, no fallback to lower entry
        wr("R7", 10, 20'hC0000, 11, 24'h055550, 2);
        rd("R7", 32'hC000_0004, 0);
        rd("R7", 32'hC000_0004, 1);
        rd("R7", 32'hC000_0004, 2);
        rd("R7", 32'hC000_0004, 3);
        rd("R8", 32'h2000_0000, 1);

        // R9 idle cycles
        step("R9", 0, 0, 0, 0, 0, 0, 0, 32'h8000_0000, 0);
        step("R9", 0, 0, 0, 0, 0, 0, 0, 32'h0, 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit we = ($urandom % 8) == 0;
            int idx = $urandom % NSEG;
            int code = ($urandom % 2) ? 11 + ($urandom % 8) : 8 + ($urandom % 24);
            int unsigned addr;
            int j = $urandom % NSEG;
            longint b = seg_base(j);
            longint s = seg_size(j);
            case ($urandom % 6)
                0: addr = int'(b);
                1: addr = int'(b + s - 1);
                2: addr = int'(b + s);
                3: addr = int'(b - 1);
                4: addr = int'(b + longint'($urandom) % s);
                default: addr = $urandom;
            endcase
            step("R4", we, idx, $urandom, code, $urandom, $urandom % 8,
                 ($urandom % 8) != 0, addr, $urandom % 4);
        end
        @(negedge clk);
        check_pending();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule